// File: doc/BRIEF.md
# Serial Result Readout Port with Daisy-Chain Forwarding

This block hands a pair of 16-bit conversion results to a host over a serial link whose clock comes from the host. A results-ready strobe delivers both words at once. They are placed into a 32-bit shift register and shifted out most significant bit first, and a select input decides which word leads. The host opens the port with chip-select and read-enable, both active low. Chip-select also decides whether host clock edges count at all. A static polarity input picks whether data advances on the rising or on the falling edge of the host clock.

Each shift moves the serial input into the bottom of the register. Once 32 shifts have gone by, the line carries whatever an upstream device supplied, so several ports can be chained onto one output wire. When a new result pair arrives while a read has started but not finished, the unread data is dropped. An error output pulses for one system clock and the new pair is loaded. A synchronous abort request clears any read in progress.

The host-side pins are brought into the system clock domain by a synchronizer, and edges are detected there. The host clock must therefore run well below the system clock.

Top module: `sro_serial_port`

## Requirements
- R1: On a results-ready strobe, the pair is loaded and later shifted out most significant bit first. With order_sel = 0, res_a occupies the first 16 bits sent and res_b the next 16. With order_sel = 1, res_b is sent first and res_a follows.
- R2: With sclk_inv = 0, the data advances one bit on each rising sclk edge. With sclk_inv = 1, it advances on each falling edge. Edges of the other polarity do not advance it.
- R3: Each shift takes the sdin level into the register. The sdin level taken at the k-th shift of a read appears on sdout after shift k+31, so after 32 shifts the line carries the upstream data in order.
- R4: A strobe that arrives after 1 to 31 shifts of the current pair raises rd_err for exactly one system clock. In the clock after that pulse, the new pair is loaded and the shift count restarts from zero.
- R5: A strobe that arrives before any shift of the current pair, or after all 32 shifts, loads the new pair without raising rd_err.
- R6: sdout is 0 whenever cs_n or rd_n is high.
- R7: sclk edges that occur while cs_n is high do not shift the register.
- R8: A one-clock pulse on abort_req clears the register and the shift count. sdout then reads 0 with the port enabled. The next strobe loads without an error.
- R9: After reset, sdout and rd_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_req | input | 1 | Synchronous request that cancels the current read |
| res_valid | input | 1 | One-cycle strobe: a new result pair is ready |
| res_a | input | WORD_W | First conversion result |
| res_b | input | WORD_W | Second conversion result |
| order_sel | input | 1 | 0: res_a sent first, 1: res_b sent first |
| sclk | input | 1 | Host serial clock |
| sclk_inv | input | 1 | 0: shift on rising edge, 1: shift on falling edge |
| cs_n | input | 1 | Active-low select; also gates sclk |
| rd_n | input | 1 | Active-low read enable for sdout |
| sdin | input | 1 | Serial input from an upstream device |
| sdout | output | 1 | Serial data output, 0 when not enabled |
| rd_err | output | 1 | One-clock pulse when an unfinished read is dropped |

## Verification
The assertions watch, on every clock:
- sdout stays low while cs_n has been high.
- The shift count only steps by one or restarts, and stays frozen while cs_n has been high and no load or abort is pending.
- rd_err lasts one cycle and follows only a strobe that landed in mid-read.
- A load follows every error pulse.
- An abort leaves the count at zero.

Bit order and word order, the chosen clock polarity, and the upstream bits arriving after the 32nd shift are only shown by the bench's scenarios. Those scenarios capture whole serial streams and compare them with the words and the upstream pattern that were supplied.

// File: rtl/sro_pkg.sv
package sro_pkg;

  // Which result word leads the serial stream.
  typedef enum logic {
    ORD_A_FIRST = 1'b0,
    ORD_B_FIRST = 1'b1
  } order_e;

  // Host-side pins carried through the synchronizer as one bundle.
  typedef struct packed {
    logic sclk;
    logic cs_n;
    logic rd_n;
    logic sdin;
  } host_pins_t;

  localparam int HOST_PINS_W = $bits(host_pins_t);

  // Reset level of the bundle: port deselected, clock and data low.
  localparam host_pins_t HOST_PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, rd_n: 1'b1, sdin: 1'b0};

endpackage

// File: rtl/sro_sync.sv
module sro_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/sro_edge.sv
module sro_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic cs_n_s,
  input  logic sclk_inv,
  output logic upd_pulse
);

  logic prev_q;
  logic rise;
  logic fall;
  logic sel_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= sclk_s;
    end
  end

  always_comb begin
    rise      = sclk_s & ~prev_q;
    fall      = ~sclk_s & prev_q;
    sel_edge  = sclk_inv ? fall : rise;
    // Select gates the host clock: edges while deselected never count.
    upd_pulse = sel_edge & ~cs_n_s;
  end

endmodule

// File: rtl/sro_ctrl.sv
module sro_ctrl
  import sro_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int PAIR_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_req,
  input  logic              res_valid,
  input  logic [WORD_W-1:0] res_a,
  input  logic [WORD_W-1:0] res_b,
  input  order_e            order_sel,
  input  logic              mid_read,
  output logic              load,
  output logic [PAIR_W-1:0] load_word,
  output logic              rd_err
);

  logic              pend_q, pend_d;
  logic              err_q,  err_d;
  logic [PAIR_W-1:0] word_q, word_d;
  logic              word_en;
  logic              busy;

  // A load already staged restarts the count, so it is not an open read.
  assign busy = mid_read & ~pend_q;

  always_comb begin
    pend_d  = 1'b0;
    err_d   = 1'b0;
    word_en = 1'b0;
    word_d  = (order_sel == ORD_B_FIRST) ? {res_b, res_a} : {res_a, res_b};
    if (abort_req) begin
      pend_d = 1'b0;
      err_d  = 1'b0;
    end else if (res_valid) begin
      pend_d  = 1'b1;
      err_d   = busy;
      word_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign load      = pend_q;
  assign load_word = word_q;
  assign rd_err    = err_q;

endmodule

// File: rtl/sro_shifter.sv
module sro_shifter #(
  parameter int  PAIR_W = 32,
  localparam int CNT_W  = $clog2(PAIR_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_req,
  input  logic              load,
  input  logic [PAIR_W-1:0] load_word,
  input  logic              shift_en,
  input  logic              sdin_s,
  output logic              msb,
  output logic [CNT_W-1:0]  cnt,
  output logic              mid_read
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(PAIR_W);

  logic [PAIR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sh_en;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    sh_en = 1'b0;
    if (abort_req) begin
      sh_d  = '0;
      cnt_d = '0;
      sh_en = 1'b1;
    end else if (load) begin
      sh_d  = load_word;
      cnt_d = '0;
      sh_en = 1'b1;
    end else if (shift_en) begin
      sh_d  = {sh_q[PAIR_W-2:0], sdin_s};
      // Saturate: longer chains keep shifting once the local pair is out.
      cnt_d = (cnt_q == FULL) ? FULL : cnt_q + 1'b1;
      sh_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign msb      = sh_q[PAIR_W-1];
  assign cnt      = cnt_q;
  assign mid_read = (cnt_q != '0) && (cnt_q != FULL);

endmodule

// File: rtl/sro_serial_port.sv
module sro_serial_port
  import sro_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_req,
  input  logic              res_valid,
  input  logic [WORD_W-1:0] res_a,
  input  logic [WORD_W-1:0] res_b,
  input  logic              order_sel,
  input  logic              sclk,
  input  logic              sclk_inv,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              sdin,
  output logic              sdout,
  output logic              rd_err
);

  localparam int PAIR_W = 2 * WORD_W;
  localparam int CNT_W  = $clog2(PAIR_W) + 1;

  host_pins_t        pins_raw;
  host_pins_t        pins_s;
  logic              upd_pulse;
  logic              load;
  logic [PAIR_W-1:0] load_word;
  logic              msb;
  logic [CNT_W-1:0]  bit_cnt;
  logic              mid_read;
  order_e            order_e_sel;

  assign pins_raw    = '{sclk: sclk, cs_n: cs_n, rd_n: rd_n, sdin: sdin};
  assign order_e_sel = order_e'(order_sel);

  sro_sync #(
    .W       (HOST_PINS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (HOST_PINS_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pins_raw),
    .dout (pins_s)
  );

  sro_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (pins_s.sclk),
    .cs_n_s   (pins_s.cs_n),
    .sclk_inv (sclk_inv),
    .upd_pulse(upd_pulse)
  );

  sro_ctrl #(
    .WORD_W(WORD_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort_req(abort_req),
    .res_valid(res_valid),
    .res_a    (res_a),
    .res_b    (res_b),
    .order_sel(order_e_sel),
    .mid_read (mid_read),
    .load     (load),
    .load_word(load_word),
    .rd_err   (rd_err)
  );

  sro_shifter #(
    .PAIR_W(PAIR_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort_req(abort_req),
    .load     (load),
    .load_word(load_word),
    .shift_en (upd_pulse),
    .sdin_s   (pins_s.sdin),
    .msb      (msb),
    .cnt      (bit_cnt),
    .mid_read (mid_read)
  );

  // Output is held at 0 unless both the select and the read enable are low.
  assign sdout = msb & ~pins_s.cs_n & ~pins_s.rd_n;

endmodule

// File: rtl/sro_serial_port_chk.sv
module sro_serial_port_chk #(
  parameter int  CNT_W = 6,
  parameter int  FULL  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             res_valid,
  input logic             abort_req,
  input logic             rd_err,
  input logic             sdout,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FULL);

  logic [3:0] cyc_q;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (cyc_q != 4'hF) begin
      cyc_q <= cyc_q + 4'd1;
    end
  end

  assign ready = (cyc_q >= 4'd6);

  // R6: deselected port drives 0
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdout);

  // R2: the count advances by one or restarts
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cnt != $past(cnt) && cnt != '0) |-> (cnt == $past(cnt) + 1'b1));

  // R7: no shifting while deselected
  a_r7_cs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)
     && !$past(abort_req) && !$past(res_valid, 2)) |-> $stable(cnt));

  // R4: the error pulse is a single clock
  a_r4_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rd_err) |=> !rd_err);

  // R4: the error follows a strobe that landed mid-read
  a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rd_err) |-> ($past(res_valid) && $past(cnt) != '0 && $past(cnt) != FULL_C));

  // R4: new pair loaded after the error pulse
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(rd_err) && !$past(abort_req)) |-> (cnt == '0));

  // R5: strobe at a read boundary raises no error
  a_r5_no_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(res_valid) && ($past(cnt) == '0 || $past(cnt) == FULL_C)) |-> !rd_err);

  // R8: abort clears the count and suppresses errors
  a_r8_abort_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(abort_req)) |-> (cnt == '0 && !rd_err));

endmodule

bind sro_serial_port sro_serial_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .res_valid(res_valid),
  .abort_req(abort_req),
  .rd_err   (rd_err),
  .sdout    (sdout),
  .cnt      (bit_cnt)
);

// File: tb/sro_serial_port_tb.sv
module sro_serial_port_tb;

  localparam int H = 6;

  logic        clk;
  logic        rst_n;
  logic        abort_req;
  logic        res_valid;
  logic [15:0] res_a;
  logic [15:0] res_b;
  logic        order_sel;
  logic        sclk;
  logic        sclk_inv;
  logic        cs_n;
  logic        rd_n;
  logic        sdin;
  logic        sdout;
  logic        rd_err;

  int checks;
  int fails;
  int err_seen;
  bit done;

  sro_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .abort_req(abort_req), .res_valid(res_valid),
    .res_a(res_a), .res_b(res_b), .order_sel(order_sel), .sclk(sclk),
    .sclk_inv(sclk_inv), .cs_n(cs_n), .rd_n(rd_n), .sdin(sdin),
    .sdout(sdout), .rd_err(rd_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) if (rd_err) err_seen++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_pair(input logic [15:0] a, input logic [15:0] b, input logic ord);
    res_a = a; res_b = b; order_sel = ord; res_valid = 1'b1;
    tick(1);
    res_valid = 1'b0;
    tick(3);
  endtask

  task automatic sclk_edge();
    if (!sclk_inv) begin
      sclk = 1'b1; tick(H); sclk = 1'b0; tick(H);
    end else begin
      sclk = 1'b0; tick(H); sclk = 1'b1; tick(H);
    end
  endtask

  task automatic open_port();
    cs_n = 1'b0; rd_n = 1'b0; tick(4);
  endtask

  task automatic close_port();
    cs_n = 1'b1; rd_n = 1'b1; sdin = 1'b0; tick(4);
  endtask

  task automatic set_polarity(input logic inv);
    sclk_inv = inv; sclk = inv; tick(6);
  endtask

  task automatic read_stream(input int n, input logic [31:0] sdv, output logic [63:0] cap);
    cap = '0;
    cap[63] = sdout;
    for (int k = 1; k <= n; k++) begin
      sdin = (k <= 32) ? sdv[32-k] : 1'b0;
      sclk_edge();
      cap[63-k] = sdout;
    end
  endtask

  // R9: reset state
  task automatic t_reset();
    check("R9 sdout after reset", {63'd0, sdout}, 64'd0);
    check("R9 rd_err after reset", {63'd0, rd_err}, 64'd0);
  endtask

  // R1, R2, R3, R5: full read with daisy forwarding
  task automatic t_read(input logic ord, input logic inv, input logic [15:0] a,
                        input logic [15:0] b, input logic [31:0] sdv, input string tag);
    logic [63:0] cap;
    logic [31:0] word;
    set_polarity(inv);
    word = ord ? {b, a} : {a, b};
    load_pair(a, b, ord);
    open_port();
    read_stream(63, sdv, cap);
    check({tag, " R1 R2 local pair order"}, {32'd0, cap[63:32]}, {32'd0, word});
    check({tag, " R3 forwarded sdin"}, {33'd0, cap[31:1]}, {33'd0, sdv[31:1]});
    err_seen = 0;
    load_pair(16'h1111, 16'h2222, 1'b0);
    check({tag, " R5 no error after complete read"}, 64'(err_seen), 64'd0);
    close_port();
  endtask

  // R7: edges while deselected are ignored
  task automatic t_cs_gate();
    set_polarity(1'b0);
    load_pair(16'hA000, 16'h0000, 1'b0);
    cs_n = 1'b1; rd_n = 1'b1;
    for (int i = 0; i < 5; i++) sclk_edge();
    open_port();
    check("R7 no shift while cs_n high", {63'd0, sdout}, 64'd1);
    sclk_edge();
    check("R7 shift resumes with cs_n low", {63'd0, sdout}, 64'd0);
    close_port();
  endtask

  // R6: output disabled unless both enables are low
  task automatic t_enable();
    load_pair(16'hFFFF, 16'hFFFF, 1'b0);
    cs_n = 1'b0; rd_n = 1'b1; tick(4);
    check("R6 rd_n high gives 0", {63'd0, sdout}, 64'd0);
    cs_n = 1'b1; rd_n = 1'b0; tick(4);
    check("R6 cs_n high gives 0", {63'd0, sdout}, 64'd0);
    cs_n = 1'b0; rd_n = 1'b0; tick(4);
    check("R6 enabled shows data", {63'd0, sdout}, 64'd1);
    close_port();
  endtask

  // R4: strobe mid-read drops data and pulses the error once
  task automatic t_error();
    logic [63:0] cap;
    set_polarity(1'b0);
    load_pair(16'h0F0F, 16'h3C3C, 1'b0);
    open_port();
    for (int i = 0; i < 10; i++) sclk_edge();
    err_seen = 0;
    res_a = 16'hC35A; res_b = 16'h9E21; order_sel = 1'b1; res_valid = 1'b1;
    tick(1);
    res_valid = 1'b0;
    check("R4 rd_err high after mid-read strobe", {63'd0, rd_err}, 64'd1);
    tick(1);
    check("R4 rd_err back low", {63'd0, rd_err}, 64'd0);
    check("R4 single pulse", 64'(err_seen), 64'd1);
    tick(2);
    read_stream(32, 32'd0, cap);
    check("R4 new pair reloaded from start", {32'd0, cap[63:32]}, {32'd0, 32'h9E21C35A});
    close_port();
  endtask

  // R5: strobe before any shift raises no error
  task automatic t_idle_load();
    load_pair(16'h1234, 16'h5678, 1'b0);
    err_seen = 0;
    open_port();
    load_pair(16'h8000, 16'h0001, 1'b0);
    check("R5 no error before first shift", 64'(err_seen), 64'd0);
    check("R5 new word visible", {63'd0, sdout}, 64'd1);
    close_port();
  endtask

  // R8: abort clears the read
  task automatic t_abort();
    set_polarity(1'b0);
    load_pair(16'hFFFF, 16'hFFFF, 1'b0);
    open_port();
    for (int i = 0; i < 5; i++) sclk_edge();
    abort_req = 1'b1; tick(1); abort_req = 1'b0; tick(2);
    check("R8 sdout 0 after abort", {63'd0, sdout}, 64'd0);
    err_seen = 0;
    load_pair(16'h8000, 16'h0000, 1'b0);
    check("R8 no error after abort", 64'(err_seen), 64'd0);
    check("R8 next pair loads", {63'd0, sdout}, 64'd1);
    close_port();
  endtask

  initial begin
    checks = 0; fails = 0; err_seen = 0; done = 1'b0;
    rst_n = 1'b0; abort_req = 1'b0; res_valid = 1'b0; res_a = '0; res_b = '0;
    order_sel = 1'b0; sclk = 1'b0; sclk_inv = 1'b0; cs_n = 1'b1; rd_n = 1'b1; sdin = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_read(1'b0, 1'b0, 16'hB3C1, 16'h4E7A, 32'hD2A5_1C6F, "rise A-first");
    t_read(1'b1, 1'b1, 16'h6A0F, 16'h91E4, 32'h35C9_E08B, "fall B-first");
    t_cs_gate();
    t_enable();
    t_error();
    t_idle_load();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule